// File: doc/BRIEF.md
# JTAG-to-SPI Bridge Shifter

This block sits behind a user-defined JTAG data register. A host that can only shift bits through the JTAG chain uses it to run arbitrary SPI transactions on a serial flash or any other SPI target. While the user register is selected and in the shift state, every TCK rising edge moves one TDI bit into the bridge. The bridge runs no SPI traffic until it sees a single 1 bit, which opens a frame. The next 32 bits, most significant first, give the number of SPI clocks in the data phase. During the data phase each TDI bit goes straight out on MOSI, one SPI clock is produced per TCK, and the chip select is held low.

Response bits from MISO come back on TDO through a chain of falling-edge registers. Each response bit therefore appears a fixed number of TCK cycles after the SPI clock that produced it, and the host appends trailing padding bits to flush them out. When the clock count runs out, the bridge releases chip select and waits for the next marker. A capture strobe or loss of select abandons any frame in progress.

Top module: `jtag_spi_bridge`

## Requirements
- R1: While idle, TDI zeros, unselected cycles and cycles with shift low leave the bridge idle with chip select high. Only a 1 on TDI in a selected shift cycle opens a frame.
- R2: The 32 bits after the marker form the SPI clock count, with the first bit received as the most significant.
- R3: Chip select (active low) goes low on the TCK falling edge after the last count bit. It stays low through the data phase and rises on the falling edge after the last data bit. It is high throughout the marker and count phases.
- R4: The SPI clock is low while TCK is low. It is high only during the high phase of TCK cycles that are selected shift cycles of the data phase, so a count of N gives exactly N SPI clock pulses.
- R5: During data-phase shift cycles MOSI equals TDI, so the bits reach the SPI target in the order shifted. MOSI is 0 at all other times.
- R6: With the default of 2 stages, TDO after any TCK falling edge equals the MISO value that was present at the previous falling edge.
- R7: A count of zero returns the bridge to idle. No chip select and no SPI clock are produced.
- R8: Select low or a capture strobe, in any phase, returns the bridge to idle at the next TCK rising edge. Chip select is high from the following falling edge.
- R9: After a frame ends by count or by abort, the bridge accepts a new marker at once.
- R10: While the synchronous active-low reset is held, chip select is high and the SPI clock, MOSI and TDO are low.
- R11: A data-phase cycle with shift low pauses the frame. Chip select stays low, no SPI clock is produced, and the remaining count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock, the only clock of the block |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | User data register selected |
| capture | input | 1 | Capture-DR strobe of the user register |
| shift | input | 1 | Shift-DR strobe of the user register |
| tdi | input | 1 | Serial data in, sampled on TCK rise |
| tdo | output | 1 | Delayed MISO, updated on TCK fall |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | Gated SPI clock |
| spi_mosi | output | 1 | SPI data to the target |
| spi_miso | input | 1 | SPI data from the target |

## Verification
Inputs are driven 5 ns after each TCK rise. The frame state moves on the following rise, and chip select, the clock enable and the MISO stages move on the falling edge that comes first. Each step therefore checks chip select, MOSI and TDO 5 ns after that fall, and checks the SPI clock 5 ns after the next rise, against the enable due from the previous fall. The reference model in the bench holds the phase, the count and the two MISO stages as plain integers. TDO is expected to equal the MISO value driven one step earlier. Whole frames are also checked by counting SPI clock pulses and collecting MOSI on their rising edges.

// File: rtl/jsb_pkg.sv
// Shared types for the JTAG-to-SPI bridge.
package jsb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a 1 marker bit
        ST_LEN  = 2'd1,   // collecting the clock count, MSB first
        ST_DATA = 2'd2    // running SPI clocks
    } jsb_state_e;
endpackage

// File: rtl/jsb_frame_fsm.sv
// Frame sequencer of the bridge. Runs on the TCK rising edge.
// Finds the marker, collects LEN_W count bits MSB first, then counts
// data-phase shift cycles down to zero.
// Assumes: sel/capture/shift come from the TAP and are stable around
// the rising edge; reset is synchronous and active low.
module jsb_frame_fsm
    import jsb_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic       tck,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       capture,
    input  logic       shift,
    input  logic       tdi,
    output jsb_state_e state_o
);
    localparam int CNT_W = (LEN_W > 1) ? $clog2(LEN_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(LEN_W - 1);

    jsb_state_e        state;
    logic [LEN_W-1:0]  len_sr;
    logic [LEN_W-1:0]  remain;
    logic [CNT_W-1:0]  bit_cnt;
    logic [LEN_W-1:0]  len_next;
    logic              abort;
    logic              step;

    assign len_next = {len_sr[LEN_W-2:0], tdi};
    assign abort    = !sel || capture;
    assign step     = sel && !capture && shift;
    assign state_o  = state;

    // Phase, count register and bit counter update
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            len_sr  <= '0;
            remain  <= '0;
            bit_cnt <= '0;
        end else if (abort) begin
            state   <= ST_IDLE;
        end else if (shift) begin
            unique case (state)
                ST_IDLE: begin
                    if (tdi) begin
                        state   <= ST_LEN;
                        len_sr  <= '0;
                        bit_cnt <= '0;
                    end
                end
                ST_LEN: begin
                    len_sr  <= len_next;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        remain <= len_next;
                        state  <= (len_next == '0) ? ST_IDLE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    remain <= remain - 1'b1;
                    if (remain == LEN_W'(1)) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_IDLE_NEEDS_MARKER: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_IDLE && !(step && tdi)) |=> state == ST_IDLE); // R1
    AST_DATA_COUNT_LIVE: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_DATA) |-> remain != '0); // R3
    AST_ZERO_COUNT_SKIPS: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_LEN && step && bit_cnt == LAST_BIT && len_next == '0) |=> state == ST_IDLE); // R7
    AST_ABORT_IDLE: assert property (@(posedge tck) disable iff (!rst_n)
        abort |=> state == ST_IDLE); // R8
    AST_PAUSE_HOLDS: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_DATA && sel && !capture && !shift) |=> (state == ST_DATA && $stable(remain))); // R11
endmodule

// File: rtl/jsb_spi_drive.sv
// SPI side drivers. Runs on the TCK falling edge.
// Registers the clock enable and chip select while TCK is low, so that
// the AND gate forming the SPI clock never glitches.
// Assumes: TDI is set while TCK is low and held through the rising edge,
// which suits an SPI mode-0 target.
module jsb_spi_drive (
    input  logic tck,
    input  logic rst_n,
    input  logic data_phase,
    input  logic sel,
    input  logic capture,
    input  logic shift,
    input  logic tdi,
    output logic spi_cs_n,
    output logic spi_sck,
    output logic spi_mosi
);
    logic en_q;
    logic cs_n_q;

    // Enable and chip select, updated while TCK is low
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            en_q   <= data_phase && sel && !capture && shift;
            cs_n_q <= !data_phase;
        end
    end

    assign spi_sck  = tck & en_q;
    assign spi_mosi = tdi & en_q;
    assign spi_cs_n = cs_n_q;
endmodule

// File: rtl/jsb_miso_pipe.sv
// Return path from MISO to TDO: STAGES falling-edge registers.
// Assumes: the SPI target changes MISO after the SPI clock rises, so the
// TCK falling edge samples a settled bit.
module jsb_miso_pipe #(
    parameter int STAGES = 2
) (
    input  logic tck,
    input  logic rst_n,
    input  logic miso,
    output logic tdo
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            // Single sampling stage
            always_ff @(negedge tck) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= miso;
            end
        end else begin : g_chain
            // Shift chain of sampling stages
            always_ff @(negedge tck) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], miso};
            end
        end
    endgenerate

    assign tdo = pipe[STAGES-1];
endmodule

// File: rtl/jtag_spi_bridge.sv
// Top of the JTAG-to-SPI bridge shifter: frame sequencer, SPI drivers and
// the MISO return pipeline.
// Assumes: a single TCK domain; the TAP controller supplies sel, capture
// and shift for the user data register.
module jtag_spi_bridge
    import jsb_pkg::*;
#(
    parameter int LEN_W       = 32,
    parameter int MISO_STAGES = 2
) (
    input  logic tck,
    input  logic rst_n,
    input  logic sel,
    input  logic capture,
    input  logic shift,
    input  logic tdi,
    output logic tdo,
    output logic spi_cs_n,
    output logic spi_sck,
    output logic spi_mosi,
    input  logic spi_miso
);
    jsb_state_e state;

    jsb_frame_fsm #(.LEN_W(LEN_W)) u_fsm (
        .tck     (tck),
        .rst_n   (rst_n),
        .sel     (sel),
        .capture (capture),
        .shift   (shift),
        .tdi     (tdi),
        .state_o (state)
    );

    jsb_spi_drive u_drive (
        .tck        (tck),
        .rst_n      (rst_n),
        .data_phase (state == ST_DATA),
        .sel        (sel),
        .capture    (capture),
        .shift      (shift),
        .tdi        (tdi),
        .spi_cs_n   (spi_cs_n),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi)
    );

    jsb_miso_pipe #(.STAGES(MISO_STAGES)) u_pipe (
        .tck   (tck),
        .rst_n (rst_n),
        .miso  (spi_miso),
        .tdo   (tdo)
    );

    AST_CS_ONLY_IN_DATA: assert property (@(posedge tck) disable iff (!rst_n)
        !spi_cs_n |-> state == ST_DATA); // R3
endmodule

// File: tb/jtag_spi_bridge_tb.sv
module jtag_spi_bridge_tb;
    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, capture = 1'b0, shift = 1'b0, tdi = 1'b0, spi_miso = 1'b0;
    logic tdo, spi_cs_n, spi_sck, spi_mosi;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int   m_mode = 0;          // 0 idle, 1 count, 2 data
    int   m_cnt = 0;
    longint m_len = 0;
    longint m_rem = 0;
    logic m_q1 = 0, m_q2 = 0;
    logic exp_en = 0;
    logic exp_cs = 1;
    int   sck_cnt = 0;
    logic [63:0] mosi_cap = '0;
    int unsigned rng = 32'h1234_5678;

    always #10 tck = ~tck;

    jtag_spi_bridge u_dut (
        .tck(tck), .rst_n(rst_n), .sel(sel), .capture(capture), .shift(shift),
        .tdi(tdi), .tdo(tdo), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always @(posedge spi_sck) begin
        sck_cnt  = sck_cnt + 1;
        mosi_cap = {mosi_cap[62:0], spi_mosi};
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    function automatic logic rnd_bit();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng[0];
    endfunction

    // One TCK cycle: drive, check after the fall, then advance the model
    task automatic step(input logic r, input logic s, input logic c, input logic sh, input logic d);
        logic m;
        m = rnd_bit();
        @(posedge tck); #5;
        chk(spi_sck === exp_en, "R4 sck high phase", spi_sck, exp_en);
        rst_n = r; sel = s; capture = c; shift = sh; tdi = d; spi_miso = m;
        @(negedge tck); #5;
        if (!r) begin
            exp_en = 0; exp_cs = 1; m_q1 = 0; m_q2 = 0;
        end else begin
            exp_en = (m_mode == 2) && s && !c && sh;
            exp_cs = (m_mode != 2);
            m_q2 = m_q1; m_q1 = m;
        end
        chk(spi_cs_n === exp_cs, r ? "R3 cs_n" : "R10 cs_n", spi_cs_n, exp_cs);
        chk(spi_mosi === (exp_en ? d : 1'b0), r ? "R5 mosi" : "R10 mosi", spi_mosi, exp_en ? d : 1'b0);
        chk(tdo === m_q2, r ? "R6 tdo" : "R10 tdo", tdo, m_q2);
        chk(spi_sck === 1'b0, "R4 sck low phase", spi_sck, 0);
        // model update for the coming rising edge
        if (!r || !s || c) m_mode = 0;
        else if (sh) begin
            case (m_mode)
                0: if (d) begin m_mode = 1; m_cnt = 0; m_len = 0; end
                1: begin
                    m_len = (m_len << 1) | d; m_cnt++;
                    if (m_cnt == 32) begin m_rem = m_len; m_mode = (m_len == 0) ? 0 : 2; end
                end
                default: begin m_rem--; if (m_rem == 0) m_mode = 0; end
            endcase
        end
    endtask

    task automatic send_count(input int n);
        step(1, 1, 0, 1, 1);                       // marker
        for (int i = 31; i >= 0; i--) step(1, 1, 0, 1, n[i]);
    endtask

    task automatic frame(input int n, input logic [63:0] pat, input int pause_at, input int pause_len);
        sck_cnt = 0; mosi_cap = '0;
        send_count(n);
        for (int i = 0; i < n; i++) begin
            if (i == pause_at)
                for (int k = 0; k < pause_len; k++) step(1, 1, 0, 0, 0);
            step(1, 1, 0, 1, pat[n-1-i]);
        end
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0);  // padding flush
        chk(sck_cnt == n, "R4 pulse count", sck_cnt, n);
        if (n > 0) chk(mosi_cap[31:0] == 32'(pat & ((64'd1 << n) - 1)), "R5 mosi order", mosi_cap[31:0], pat);
        chk(spi_cs_n === 1'b1, "R9 cs_n after frame", spi_cs_n, 1);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 1);
        // R1: zeros, unselected ones, ones with shift low keep idle
        for (int i = 0; i < 6; i++) step(1, 1, 0, 1, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 1);
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 1);
        chk(spi_cs_n === 1'b1, "R1 idle cs_n", spi_cs_n, 1);
        sck_cnt = 0;
        for (int i = 0; i < 40; i++) step(1, 1, 0, 1, 0);
        chk(sck_cnt == 0, "R1 no sck from zeros", sck_cnt, 0);
        // R2 and R4: 24-clock frame, identification style
        frame(24, 64'h9F0000, -1, 0);
        // R2: small count, MSB first
        frame(5, 64'h15, -1, 0);
        // R7: zero count, then R9 immediate next frame
        sck_cnt = 0;
        send_count(0);
        step(1, 1, 0, 1, 0);
        chk(spi_cs_n === 1'b1, "R7 cs_n stays high", spi_cs_n, 1);
        chk(sck_cnt == 0, "R7 no sck", sck_cnt, 0);
        frame(8, 64'hA5, -1, 0);
        // R11: pause inside the data phase
        frame(16, 64'hC3_5A, 7, 3);
        // R8: capture abort mid data
        sck_cnt = 0;
        send_count(16);
        for (int i = 0; i < 5; i++) step(1, 1, 0, 1, 1);
        step(1, 1, 1, 0, 0);
        step(1, 1, 0, 0, 0);
        chk(spi_cs_n === 1'b1, "R8 capture abort cs_n", spi_cs_n, 1);
        chk(sck_cnt == 5, "R8 capture abort sck", sck_cnt, 5);
        // R8: deselect during count phase
        step(1, 1, 0, 1, 1);
        for (int i = 0; i < 10; i++) step(1, 1, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        sck_cnt = 0;
        for (int i = 0; i < 30; i++) step(1, 1, 0, 1, 0);
        chk(sck_cnt == 0, "R8 deselect abort sck", sck_cnt, 0);
        // R9: clean frame after aborts
        frame(12, 64'h6B9, -1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule